// File: doc/BRIEF.md
# Multi-Sensor One-Wire Temperature Logger

This block is the bus master for a single open-drain wire shared by several digital thermometers. On a programmable schedule it resets the bus and checks for a presence pulse. It then broadcasts a start-conversion command to every sensor and waits a programmable conversion time. After that it addresses each sensor in turn by its 64-bit identity code and reads back its 16-bit temperature. The master generates all reset, presence-sampling and bit-slot timing itself.

Every reading becomes a 40-bit log entry in a FIFO, tagged with the sensor index and a scan counter that serves as a timestamp. A slow-control host reads the history through a first-word-fall-through read port. For each regulation output there is a pair of signed thresholds, and the output switches with hysteresis on the readings of its sensor (for example, a fan command). Writes from the host load the identity codes, thresholds, timing values and the run control.

Top module: `thermo_bus_logger`

## Requirements
- R1: After reset the wire is released (`ow_pull`=0), `fifo_empty`=1, `presence_err`=0, `fifo_ovf`=0 and all `reg_out` bits are 0.
- R2: A bus reset holds the wire low for 480 µs and then releases it for 480 µs. The wire is sampled 70 µs after release. If no device pulls it low, `presence_err` is set and stays set, and the scan is abandoned with nothing logged.
- R3: Each scan starts with a bus reset. It then sends byte 0xCC followed by byte 0x44, least significant bit first, and leaves the wire released for `conv_ms` milliseconds (register address 0x01).
- R4: After the conversion wait, sensors are read in ascending index order. For each one the master sends a bus reset, byte 0x55, the 64-bit identity code (LSB first) and byte 0xBE, then reads 16 bits LSB first. The code of sensor s, word k (16 bits, k=0 least significant) is written at address 0x40 + 4·s + k.
- R5: A log entry is {index[39:32], temperature[31:16], timestamp[15:0]}. `fifo_data` shows the oldest entry while `fifo_empty`=0. A cycle with `fifo_pop`=1 removes it. A pop while empty is ignored.
- R6: The timestamp counter starts at 0 and advances by one at the end of every scan attempt, including abandoned ones. All entries of one scan carry the same value.
- R7: Output j follows the readings of sensor j. It sets when the signed reading is above the high threshold (address 0x81 + 2·j), clears when it is below the low threshold (address 0x80 + 2·j), and otherwise holds its state.
- R8: A reading that arrives when the FIFO is full is dropped and sets the sticky `fifo_ovf`. If a pop happens in the same cycle as the arrival, the reading is stored and the flag is left alone.
- R9: A write to address 0x00 with bit 1 set clears `presence_err` and `fifo_ovf`. Bit 0 of the same register is the run enable.
- R10: After a scan the master waits `gap_ms` milliseconds (address 0x02). It then starts the next scan if the enable bit is 1; otherwise it stays idle and issues no bus reset.
- R11: Every write slot lasts 70 µs and pulls the wire low for 6 µs to send a 1 or for 60 µs to send a 0. A read slot pulls the wire low for 6 µs and samples the wire 15 µs after the slot starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ow_in | input | 1 | Sensed level of the shared wire |
| ow_pull | output | 1 | 1 turns on the open-drain pull-down of the wire |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 16 | Register write data |
| fifo_pop | input | 1 | Remove the oldest log entry |
| fifo_data | output | 40 | Oldest log entry |
| fifo_empty | output | 1 | Log FIFO holds no entry |
| presence_err | output | 1 | Sticky: a bus reset saw no presence pulse |
| fifo_ovf | output | 1 | Sticky: a reading was dropped on a full FIFO |
| reg_out | output | NUM_REG | Regulation command outputs |

## Verification
A new reading can reach the log in the same cycle as a host pop, and this matters most when the FIFO is full. The bench fills the FIFO and stops popping. It then counts the read slots served by its sensor model, so it knows the exact cycle in which the next reading is stored, and it asserts a single pop in that cycle. The check passes only if `fifo_ovf` stays clear and the drained contents show that the oldest entry left and the new one entered. The next reading, with no pop beside it, must then be dropped and set the flag.

// File: rtl/thermo_bus_logger.sv
module thermo_bus_logger #(
  parameter int NUM_SENSORS   = 4,
  parameter int NUM_REG       = 2,
  parameter int FIFO_DEPTH    = 16,
  parameter int CYC_PER_US    = 250,
  parameter int CONV_MS_RESET = 750,
  parameter int GAP_MS_RESET  = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ow_in,
  output logic               ow_pull,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [15:0]        wr_data,
  input  logic               fifo_pop,
  output logic [39:0]        fifo_data,
  output logic               fifo_empty,
  output logic               presence_err,
  output logic               fifo_ovf,
  output logic [NUM_REG-1:0] reg_out
);

  localparam logic [31:0] T_RST  = 32'(480 * CYC_PER_US);
  localparam logic [31:0] T_PDS  = 32'(70 * CYC_PER_US);
  localparam logic [31:0] T_SLOT = 32'(70 * CYC_PER_US);
  localparam logic [31:0] T_LO0  = 32'(60 * CYC_PER_US);
  localparam logic [31:0] T_LO1  = 32'(6 * CYC_PER_US);
  localparam logic [31:0] T_RSMP = 32'(15 * CYC_PER_US);
  localparam logic [31:0] CYC_MS = 32'(1000 * CYC_PER_US);
  localparam int IDXW = (NUM_SENSORS > 1) ? $clog2(NUM_SENSORS) : 1;
  localparam int AW   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

  typedef enum logic [2:0] {S_IDLE, S_RSTL, S_RSTW, S_TX, S_RX, S_CONV, S_GAP} st_t;

  st_t                st;
  logic [31:0]        tmr;
  logic [IDXW-1:0]    sidx;
  logic               rd_phase;
  logic               pres;
  logic [79:0]        tx_sh;
  logic [6:0]         bit_cnt;
  logic [15:0]        rx_sh;
  logic               ow_s1, ow_s2;
  logic [15:0]        ts;
  logic               enable;
  logic [15:0]        conv_ms, gap_ms;
  logic [63:0]        rom   [NUM_SENSORS];
  logic signed [15:0] thr_hi [NUM_REG];
  logic signed [15:0] thr_lo [NUM_REG];
  logic [39:0]        mem   [FIFO_DEPTH];
  logic [AW:0]        wr_ptr, rd_ptr;

  wire [31:0] conv_lim  = 32'(conv_ms) * CYC_MS;
  wire [31:0] gap_lim   = 32'(gap_ms) * CYC_MS;
  wire        slot_end  = (tmr == T_SLOT - 1);
  wire        push_req  = (st == S_RX) && slot_end && (bit_cnt == 7'd1);
  wire        last_sens = (sidx == IDXW'(NUM_SENSORS - 1));
  wire        ctrl_wr   = wr_en && (wr_addr == 8'h00);
  wire        clr_flags = ctrl_wr && wr_data[1];
  wire [AW:0] fill      = wr_ptr - rd_ptr;
  wire        fifo_full = (fill == (AW+1)'(FIFO_DEPTH));
  wire        do_pop    = fifo_pop && !fifo_empty;
  wire        do_push   = push_req && (!fifo_full || do_pop);

  assign fifo_empty = (wr_ptr == rd_ptr);
  assign fifo_data  = mem[rd_ptr[AW-1:0]];
  assign ow_pull = (st == S_RSTL)
                 || ((st == S_TX) && (tmr < (tx_sh[0] ? T_LO1 : T_LO0)))
                 || ((st == S_RX) && (tmr < T_LO1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ow_s1 <= 1'b1;
      ow_s2 <= 1'b1;
    end else begin
      ow_s1 <= ow_in;
      ow_s2 <= ow_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable  <= 1'b0;
      conv_ms <= 16'(CONV_MS_RESET);
      gap_ms  <= 16'(GAP_MS_RESET);
      for (int s = 0; s < NUM_SENSORS; s++) rom[s] <= '0;
      for (int j = 0; j < NUM_REG; j++) begin
        thr_hi[j] <= 16'sh7fff;
        thr_lo[j] <= 16'sh8000;
      end
    end else if (wr_en) begin
      case (wr_addr[7:6])
        2'b00: begin
          if (wr_addr[5:0] == 6'd0) enable  <= wr_data[0];
          if (wr_addr[5:0] == 6'd1) conv_ms <= wr_data;
          if (wr_addr[5:0] == 6'd2) gap_ms  <= wr_data;
        end
        2'b01:
          for (int s = 0; s < NUM_SENSORS; s++)
            if (wr_addr[5:2] == 4'(s)) rom[s][wr_addr[1:0]*16 +: 16] <= wr_data;
        2'b10:
          for (int j = 0; j < NUM_REG; j++)
            if (wr_addr[5:1] == 5'(j)) begin
              if (wr_addr[0]) thr_hi[j] <= wr_data;
              else            thr_lo[j] <= wr_data;
            end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      tmr          <= '0;
      sidx         <= '0;
      rd_phase     <= 1'b0;
      pres         <= 1'b0;
      tx_sh        <= '0;
      bit_cnt      <= '0;
      rx_sh        <= '0;
      ts           <= '0;
      presence_err <= 1'b0;
    end else begin
      if (clr_flags) presence_err <= 1'b0;
      tmr <= tmr + 32'd1;
      case (st)
        S_IDLE: begin
          tmr <= '0;
          if (enable) begin
            st       <= S_RSTL;
            rd_phase <= 1'b0;
            sidx     <= '0;
          end
        end
        S_RSTL:
          if (tmr == T_RST - 1) begin
            tmr <= '0;
            st  <= S_RSTW;
          end
        S_RSTW: begin
          if (tmr == T_PDS) pres <= !ow_s2;
          if (tmr == T_RST - 1) begin
            tmr <= '0;
            if (!pres) begin
              presence_err <= 1'b1;
              ts           <= ts + 16'd1;
              st           <= S_GAP;
            end else if (!rd_phase) begin
              tx_sh   <= {64'd0, 8'h44, 8'hcc};
              bit_cnt <= 7'd16;
              st      <= S_TX;
            end else begin
              tx_sh   <= {8'hbe, rom[sidx], 8'h55};
              bit_cnt <= 7'd80;
              st      <= S_TX;
            end
          end
        end
        S_TX:
          if (slot_end) begin
            tmr     <= '0;
            tx_sh   <= {1'b0, tx_sh[79:1]};
            bit_cnt <= bit_cnt - 7'd1;
            if (bit_cnt == 7'd1) begin
              if (rd_phase) begin
                bit_cnt <= 7'd16;
                st      <= S_RX;
              end else begin
                st <= S_CONV;
              end
            end
          end
        S_CONV:
          if (tmr + 32'd1 >= conv_lim) begin
            tmr      <= '0;
            rd_phase <= 1'b1;
            sidx     <= '0;
            st       <= S_RSTL;
          end
        S_RX: begin
          if (tmr == T_RSMP) rx_sh <= {ow_s2, rx_sh[15:1]};
          if (slot_end) begin
            tmr     <= '0;
            bit_cnt <= bit_cnt - 7'd1;
            if (bit_cnt == 7'd1) begin
              if (last_sens) begin
                ts <= ts + 16'd1;
                st <= S_GAP;
              end else begin
                sidx <= sidx + IDXW'(1);
                st   <= S_RSTL;
              end
            end
          end
        end
        S_GAP:
          if (tmr + 32'd1 >= gap_lim) begin
            tmr      <= '0;
            rd_phase <= 1'b0;
            sidx     <= '0;
            st       <= enable ? S_RSTL : S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fifo_ovf <= 1'b0;
    end else begin
      if (do_push) begin
        mem[wr_ptr[AW-1:0]] <= {8'(sidx), rx_sh, ts};
        wr_ptr <= wr_ptr + (AW+1)'(1);
      end
      if (do_pop) rd_ptr <= rd_ptr + (AW+1)'(1);
      if (push_req && !do_push) fifo_ovf <= 1'b1;
      else if (clr_flags)       fifo_ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_out <= '0;
    end else if (push_req) begin
      for (int j = 0; j < NUM_REG; j++)
        if (sidx == IDXW'(j)) begin
          if ($signed(rx_sh) > thr_hi[j])      reg_out[j] <= 1'b1;
          else if ($signed(rx_sh) < thr_lo[j]) reg_out[j] <= 1'b0;
        end
    end
  end

  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_CONV || st == S_GAP) |-> !ow_pull);

  p_err_after_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(presence_err) |-> $past(st == S_RSTW));

  p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && fifo_pop && !push_req) |=> fifo_empty);

  p_ts_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ts) |-> (ts == $past(ts) + 16'd1));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && fifo_full && !fifo_pop) |=> fifo_ovf);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ovf && !clr_flags) |=> fifo_ovf);

  for (genvar j = 0; j < NUM_REG; j++) begin : g_chk
    p_reg_on_reading_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_out[j]) |-> $past(push_req && (sidx == IDXW'(j))));
  end

endmodule

// File: tb/thermo_bus_logger_bench.sv
`timescale 1ns/1ps
module thermo_bus_logger_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        fifo_pop = 1'b0;
  logic        ow_pull;
  logic [39:0] fifo_data;
  logic        fifo_empty, presence_err, fifo_ovf;
  logic [1:0]  reg_out;
  logic        mdl_pull = 1'b0;
  wire         ow_in = ~(ow_pull | mdl_pull);

  always #2 clk = ~clk;

  thermo_bus_logger #(
    .NUM_SENSORS(2), .NUM_REG(2), .FIFO_DEPTH(4),
    .CYC_PER_US(1), .CONV_MS_RESET(1), .GAP_MS_RESET(1)
  ) u_thermo_bus_logger (
    .clk(clk), .rst_n(rst_n), .ow_in(ow_in), .ow_pull(ow_pull),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fifo_pop(fifo_pop), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .presence_err(presence_err), .fifo_ovf(fifo_ovf), .reg_out(reg_out)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    end
  endtask

  // sensor model
  logic [63:0] rom_m [2] = '{64'h5d00_0000_12a3_4b28, 64'hc700_0000_98f1_0e28};
  logic [15:0] temp_m [2];
  bit          no_presence = 0;
  int          fails = 0, rst_cnt = 0, rd_slots = 0, conv_seen = 0;
  longint      rst_w = 0, w1_w = 0, w0_w = 0;
  logic [79:0] mrx = '0;
  int          nbits = 0;
  bit          sending = 0;
  logic [15:0] send_sh = '0;
  int          send_n = 0;

  initial begin
    forever begin
      longint t0, w;
      @(posedge ow_pull);
      t0 = $time;
      if (sending) begin
        bit b;
        b = send_sh[0];
        rd_slots++;
        if (!b) mdl_pull = 1'b1;
        @(negedge ow_pull);
        if (!b) begin
          repeat (34) @(posedge clk);
          #1 mdl_pull = 1'b0;
        end
        send_sh = send_sh >> 1;
        send_n--;
        if (send_n == 0) sending = 0;
      end else begin
        @(negedge ow_pull);
        w = ($time - t0) / 4;
        if (w > 300) begin
          rst_w = w;
          rst_cnt++;
          nbits = 0;
          if (no_presence) fails++;
          else begin
            repeat (20) @(posedge clk);
            #1 mdl_pull = 1'b1;
            repeat (100) @(posedge clk);
            #1 mdl_pull = 1'b0;
          end
        end else begin
          bit b;
          b = (w < 30);
          if (b) w1_w = w; else w0_w = w;
          mrx = {b, mrx[79:1]};
          nbits++;
          if (nbits == 16 && mrx[79:64] == 16'h44cc) conv_seen++;
          if (nbits == 80 && mrx[7:0] == 8'h55 && mrx[79:72] == 8'hbe)
            for (int s = 0; s < 2; s++)
              if (mrx[71:8] == rom_m[s]) begin
                send_sh = temp_m[s];
                send_n  = 16;
                sending = 1;
              end
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop_chk(input string tag, input logic [39:0] exp);
    while (fifo_empty) @(negedge clk);
    cmp(tag, fifo_data, exp);
    fifo_pop = 1'b1;
    @(negedge clk);
    fifo_pop = 1'b0;
  endtask

  // {temp sensor0, temp sensor1, expected reg_out}
  localparam logic [33:0] VEC [3] = '{
    {16'h0100, 16'h0060, 2'b10},
    {16'h01a0, 16'h0000, 2'b11},
    {16'h0160, 16'hffe0, 2'b01}
  };

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    temp_m[0] = VEC[0][33:18];
    temp_m[1] = VEC[0][17:2];
    repeat (10) @(negedge clk);
    cmp("R1 ow_pull", ow_pull, 0);
    cmp("R1 fifo_empty", fifo_empty, 1);
    cmp("R1 presence_err", presence_err, 0);
    cmp("R1 fifo_ovf", fifo_ovf, 0);
    cmp("R1 reg_out", reg_out, 0);
    rst_n = 1'b1;
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 4; k++)
        wr(8'h40 + 8'(4*s + k), rom_m[s][16*k +: 16]);
    wr(8'h80, 16'h0140); wr(8'h81, 16'h0190);
    wr(8'h82, 16'hfff0); wr(8'h83, 16'h0050);
    wr(8'h01, 16'd1); wr(8'h02, 16'd1);
    wr(8'h00, 16'h0001);

    for (int k = 0; k < 3; k++) begin
      pop_chk("R4 R5 R6 sensor0 entry", {8'd0, VEC[k][33:18], 16'(k)});
      pop_chk("R4 R5 R6 sensor1 entry", {8'd1, VEC[k][17:2], 16'(k)});
      cmp("R7 hysteresis outputs", reg_out, VEC[k][1:0]);
      if (k < 2) begin
        temp_m[0] = VEC[k+1][33:18];
        temp_m[1] = VEC[k+1][17:2];
      end
    end
    cmp("R3 convert bytes seen", conv_seen, 3);

    temp_m[0] = 16'h0120;
    temp_m[1] = 16'hffe0;
    wait (rd_slots == 176);
    repeat (69) @(posedge clk);
    @(negedge clk);
    cmp("R8 fifo full before pop", fifo_empty, 0);
    cmp("R8 head before pop", fifo_data, {8'd0, 16'h0120, 16'd3});
    fifo_pop = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fifo_pop = 1'b0;
    cmp("R8 no overflow with same-cycle pop", fifo_ovf, 0);
    wait (rd_slots == 192);
    repeat (80) @(negedge clk);
    cmp("R8 overflow on full", fifo_ovf, 1);
    pop_chk("R8 kept entry 1", {8'd1, 16'hffe0, 16'd3});
    pop_chk("R8 kept entry 2", {8'd0, 16'h0120, 16'd4});
    pop_chk("R8 kept entry 3", {8'd1, 16'hffe0, 16'd4});
    pop_chk("R8 stored on pop", {8'd0, 16'h0120, 16'd5});
    cmp("R8 dropped entry absent", fifo_empty, 1);
    cmp("R7 outputs cleared", reg_out, 2'b00);
    wr(8'h00, 16'h0002);
    cmp("R9 overflow cleared", fifo_ovf, 0);

    begin
      int r0;
      r0 = rst_cnt;
      repeat (3000) @(negedge clk);
      cmp("R10 no reset while disabled", rst_cnt, r0);
      cmp("R10 nothing logged while disabled", fifo_empty, 1);
    end

    no_presence = 1;
    fails = 0;
    wr(8'h00, 16'h0001);
    repeat (2500) @(negedge clk);
    cmp("R2 presence error set", presence_err, 1);
    cmp("R2 abandoned scan logs nothing", fifo_empty, 1);
    no_presence = 0;
    while (fifo_empty) @(negedge clk);
    cmp("R6 timestamp counts abandoned scans", fifo_data, {8'd0, 16'h0120, 16'(6 + fails)});
    cmp("R2 error flag still held", presence_err, 1);
    cmp("R2 reset pulse width", rst_w, 480);
    cmp("R11 write-one low time", w1_w, 6);
    cmp("R11 write-zero low time", w0_w, 60);
    wr(8'h00, 16'h0002);
    cmp("R9 presence error cleared", presence_err, 0);

    report();
    $finish;
  end

endmodule